// File: doc/BRIEF.md
# Address-Decode-Error Interrupt Register Group

This block is a small interrupt register group on a 32-bit register read/write port. It holds one sticky status bit that records an address-decode-error event raised by neighbouring logic, and one mask bit that gates that status onto a single level-sensitive interrupt line. Software clears the status by writing a one to it.

Software cannot write the mask directly. Instead, two strobe registers change it: writing a one to the unmask register clears the mask, and writing a one to the re-mask register sets it. Neither strobe register stores anything. The mask comes out of reset set, so the source starts silenced. Only full-word writes, with all four byte strobes active, take effect.

Top module: `decerr_irq_regs`

## Requirements
- R1: After reset the status bit (offset 0x4, bit 0) reads 0, the mask bit (offset 0x8, bit 0) reads 1 and `irq_o` is low.
- R2: A cycle with `hw_event` high sets the status bit from the next cycle on.
- R3: A full-word write to offset 0x4 with data bit 0 equal to 1 clears the status bit. The same write with bit 0 equal to 0 leaves it unchanged.
- R4: When `hw_event` and a clearing write to offset 0x4 occur in the same cycle, the status bit stays set.
- R5: Writes to the mask register at offset 0x8 leave the mask bit unchanged.
- R6: A full-word write to offset 0xC with data bit 0 equal to 1 clears the mask bit. With bit 0 equal to 0 the write has no effect.
- R7: A full-word write to offset 0x10 with data bit 0 equal to 1 sets the mask bit.
- R8: Reads of offsets 0xC and 0x10 always return 0.
- R9: `irq_o` is high exactly when the status bit is 1 and the mask bit is 0, one cycle after the register update that causes it.
- R10: A write with any byte strobe in `wstrb` inactive changes no register.
- R11: Bits 31:1 of every register read as 0. Reads of any offset other than 0x4, 0x8, 0xC and 0x10 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request this cycle |
| wstrb | input | 4 | Byte strobes; all four must be set for a write to act |
| rd_en | input | 1 | Read request this cycle; `rdata` is valid in the same cycle |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, zero when no read is requested |
| hw_event | input | 1 | Address-decode-error event pulse |
| irq_o | output | 1 | Level interrupt output |

## Verification
The status bit is exercised by an event alone, by a clear write alone, by a write of zero, and by an event and a clear in the same cycle. These cases separate a correct sticky write-one-to-clear bit from one that clears on any write or lets the write win. The mask is driven through the unmask and re-mask strobes, through direct writes to the mask offset, through strobes with bit 0 at zero and through partial-strobe writes, which tells real strobe decoding apart from a plain read/write register. The interrupt line is sampled for every status and mask combination, and unused offsets and upper bits are read back to expose stray decode.

// File: rtl/decerr_irq_regs.sv
module decerr_irq_regs #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wstrb,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              hw_event,
  output logic              irq_o
);

  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFS_UNM  = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] OFS_REM  = ADDR_W'(16);

  logic status_q, mask_q;
  logic wr_full, clr_hit, unm_hit, rem_hit;
  logic unused_bits;

  assign wr_full = wr_en && (&wstrb);
  assign clr_hit = wr_full && (addr == OFS_STAT) && wdata[0];
  assign unm_hit = wr_full && (addr == OFS_UNM)  && wdata[0];
  assign rem_hit = wr_full && (addr == OFS_REM)  && wdata[0];
  assign unused_bits = ^wdata[DATA_W-1:1];

  always_ff @(posedge clk) begin
    if (!rst_n)        status_q <= 1'b0;
    else if (hw_event) status_q <= 1'b1;
    else if (clr_hit)  status_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= 1'b1;
    else if (rem_hit) mask_q <= 1'b1;
    else if (unm_hit) mask_q <= 1'b0;
  end

  assign irq_o = status_q & ~mask_q;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr == OFS_STAT)      rdata[0] = status_q;
      else if (addr == OFS_MASK) rdata[0] = mask_q;
    end
  end

  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hw_event |=> status_q);

  a_r3_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !hw_event) |=> !status_q);

  a_r5_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(unm_hit || rem_hit) |=> $stable(mask_q));

  a_r7_remask: assert property (@(posedge clk) disable iff (!rst_n)
    rem_hit |=> (mask_q && !irq_o));

  a_r8_strobes_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == OFS_UNM || addr == OFS_REM)) |-> (rdata == '0));

  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(hw_event || unm_hit));

  a_r10_partial_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(&wstrb) && !hw_event) |=> ($stable(mask_q) && $stable(status_q)));

endmodule

// File: tb/decerr_irq_regs_tb.sv
`timescale 1ns/100ps
module decerr_irq_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wstrb = 4'h0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = 8'h0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic        hw_event = 1'b0;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] val; string tag; } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  decerr_irq_regs #(.ADDR_W(8), .DATA_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wstrb(wstrb), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .hw_event(hw_event), .irq_o(irq_o)
  );

  always @(negedge clk) begin
    if (rd_en) begin
      exp_t e;
      n_chk++;
      if (sb.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard empty: act %h exp none", rdata);
      end else begin
        e = sb.pop_front();
        if (rdata !== e.val) begin
          n_fail++;
          $display("FAIL %s: act %h exp %h", e.tag, rdata, e.val);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d,
                    input logic [3:0] s = 4'hF, input logic ev = 1'b0);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d; wstrb = s; hw_event = ev;
    @(posedge clk); #1;
    wr_en = 1'b0; wstrb = 4'h0; hw_event = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_t e;
    e.val = exp; e.tag = tag;
    sb.push_back(e);
    @(posedge clk); #1;
    rd_en = 1'b1; addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic pulse_event();
    @(posedge clk); #1; hw_event = 1'b1;
    @(posedge clk); #1; hw_event = 1'b0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk);
    n_chk++;
    if (irq_o !== exp) begin
      n_fail++;
      $display("FAIL %s irq: act %b exp %b", tag, irq_o, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd(8'h04, 32'h0, "R1 status after reset");
    rd(8'h08, 32'h1, "R1 mask after reset");
    chk_irq(1'b0, "R1");
    pulse_event();
    rd(8'h04, 32'h1, "R2 event sets status");
    chk_irq(1'b0, "R9 masked");
    wr(8'h0C, 32'h1);
    rd(8'h08, 32'h0, "R6 unmask clears mask");
    chk_irq(1'b1, "R9 pending unmasked");
    rd(8'h0C, 32'h0, "R8 unmask reads zero");
    rd(8'h10, 32'h0, "R8 remask reads zero");
    wr(8'h04, 32'hFFFF_FFFE);
    rd(8'h04, 32'h1, "R3 zero write keeps status");
    wr(8'h04, 32'h1);
    rd(8'h04, 32'h0, "R3 one write clears status");
    chk_irq(1'b0, "R9 cleared");
    wr(8'h04, 32'h1, 4'hF, 1'b1);
    rd(8'h04, 32'h1, "R4 event beats clear");
    wr(8'h08, 32'h1);
    rd(8'h08, 32'h0, "R5 mask write ignored");
    chk_irq(1'b1, "R5");
    wr(8'h10, 32'h1, 4'h1);
    rd(8'h08, 32'h0, "R10 partial remask ignored");
    wr(8'h04, 32'hFFFF_FFFF, 4'h7);
    rd(8'h04, 32'h1, "R10 partial clear ignored");
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h08, 32'h1, "R7 remask sets mask");
    chk_irq(1'b0, "R7");
    wr(8'h0C, 32'hFFFF_FFFE);
    rd(8'h08, 32'h1, "R6 zero unmask no effect");
    rd(8'h04, 32'h1, "R11 upper status bits zero");
    rd(8'h00, 32'h0, "R11 unused offset 0x0");
    rd(8'h14, 32'h0, "R11 unused offset 0x14");
    rd(8'h05, 32'h0, "R11 misaligned offset");
    repeat (2) @(posedge clk);
    if (sb.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard leftover: act %0d exp 0", sb.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired: act hung exp done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule